// File: doc/BRIEF.md
# Strided Tile Transfer Address Generator

This block drives the address side of a tile transfer between off-chip memory and one of two on-chip scratch buffers. Software first writes a base address, and then an iteration count and a stride for each level of two loop groups. The intra-tile group walks the elements of one tile. The tile-stepping group moves the walk from one tile to the next. A start command then makes the engine issue one request per element. Each request carries an off-chip address, a linear on-chip element index, the direction (fill or drain), the selected buffer and that buffer's current double-buffer tag.

The off-chip address of each beat is the base plus the sum of every loop index times that loop's stride. The data may therefore lie on lines that are far apart and not contiguous, as long as they form a static strided pattern. Requests use a valid/ready handshake, and the loop state moves forward only on an accepted beat. When the last beat is accepted, the engine raises a one-cycle completion pulse and toggles the tag of the buffer it served. A producer and a consumer can use that tag to alternate halves, so the next tile can be prefetched while the current one is still in use.

Top module: `tile_xfer_agen`

## Requirements
- R1: During and after reset, `req_valid` and `done` are low and both buffer tags (`buf_tag`) are 0.
- R2: A write with `cfg_we` high applies `cfg_data` according to `cfg_func`: 0 sets the base address, 1 sets a tile-stepping count, 2 sets a tile-stepping stride, 3 sets an intra-tile count and 4 sets an intra-tile stride. `cfg_level` picks the level, and level 0 is innermost. After reset every count is 1, every stride is 0 and the base is 0, so a start with no configuration yields exactly one beat at address 0.
- R3: Beats are ordered with intra-tile level 0 innermost, then intra-tile levels 1 to 3, then tile-stepping levels 0 to 3 (level 3 outermost). Each beat's `req_addr` equals base plus the sum of index times stride over all eight levels, modulo 2^ADDR_W. The number of beats is the product of the effective counts.
- R4: A level whose count is 0 or 1 runs once with index 0 and has no effect on the sequence.
- R5: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_local` and the other request fields hold their values. The engine advances only on a beat where both signals are high.
- R6: `req_local` is 0 on the first beat of a transfer and rises by 1 on each accepted beat. `req_store` and `req_buf` repeat the direction and buffer given at start. `req_tag` holds the chosen buffer's tag as it was at start.
- R7: `done` is high for exactly one cycle, in the cycle after the final beat is accepted. `req_valid` is low in that same cycle.
- R8: Each completed transfer inverts the tag of the buffer it used and leaves the other buffer's tag unchanged.
- R9: A `start` while a transfer is in progress is ignored. It changes neither the running sequence nor its buffer or direction.
- R10: Configuration writes made while a transfer is in progress are ignored.
- R11: An accepted start raises `req_valid` in the next cycle with `req_addr` equal to the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_func | input | 3 | Configuration function code |
| cfg_level | input | 2 | Loop level selected by the write |
| cfg_data | input | ADDR_W | Configuration value |
| start | input | 1 | Start command |
| start_store | input | 1 | Direction: 1 drains the buffer (store), 0 fills it (load) |
| start_buf | input | 1 | Target buffer, 0 or 1 |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the memory side |
| req_addr | output | ADDR_W | Off-chip address |
| req_local | output | LOCAL_W | On-chip element index |
| req_store | output | 1 | Direction of the running transfer |
| req_buf | output | 1 | Buffer of the running transfer |
| req_tag | output | 1 | Double-buffer tag used by the running transfer |
| done | output | 1 | One-cycle completion pulse |
| buf_tag | output | 2 | Current tag of each buffer |

## Verification
Some rules are checked by assertions on every cycle: the request holds steady under back-pressure, every loop index stays below its count, configuration is frozen and starts have no effect while busy, and each completion pulse follows a busy cycle and flips exactly one tag. Other properties can only be shown by the bench's scenarios, which compare against a scoreboard built from the loop formula. These are the full address order across eight nested levels, the effect of a zero or one count, the running on-chip index, and which buffer's tag toggles. The scenarios also show that a new start or a configuration write made during a transfer has no visible effect later.

// File: rtl/tile_xfer_pkg.sv
package tile_xfer_pkg;
  typedef enum logic [2:0] {
    FN_BASE        = 3'd0,
    FN_STEP_COUNT  = 3'd1,
    FN_STEP_STRIDE = 3'd2,
    FN_ELEM_COUNT  = 3'd3,
    FN_ELEM_STRIDE = 3'd4
  } cfg_fn_e;
endpackage

// File: rtl/xfer_cfg_regs.sv
module xfer_cfg_regs
  import tile_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2,
  localparam int NL    = 2 * LEVELS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          busy,
  input  logic                          we,
  input  logic [2:0]                    func,
  input  logic [LVL_W-1:0]              lvl,
  input  logic [ADDR_W-1:0]             data,
  output logic [ADDR_W-1:0]             base,
  output logic [NL-1:0][CNT_W-1:0]      cnt,
  output logic [NL-1:0][ADDR_W-1:0]     stride
);
  // intra-tile levels occupy slots 0..LEVELS-1, tile-stepping levels the rest
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      for (int i = 0; i < NL; i++) begin
        cnt[i]    <= CNT_W'(1);
        stride[i] <= '0;
      end
    end else if (we && !busy) begin
      case (cfg_fn_e'(func))
        FN_BASE:        base                       <= data;
        FN_ELEM_COUNT:  cnt[int'(lvl)]             <= data[CNT_W-1:0];
        FN_ELEM_STRIDE: stride[int'(lvl)]          <= data;
        FN_STEP_COUNT:  cnt[LEVELS + int'(lvl)]    <= data[CNT_W-1:0];
        FN_STEP_STRIDE: stride[LEVELS + int'(lvl)] <= data;
        default: ;
      endcase
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(base) && $stable(cnt) && $stable(stride));
endmodule

// File: rtl/xfer_loop_level.sv
module xfer_loop_level #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step_in,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] stride,
  output logic              carry_out,
  output logic [ADDR_W-1:0] off_nx
);
  logic [CNT_W-1:0]  idx_q, idx_nx;
  logic [ADDR_W-1:0] off_q;
  logic              at_end;

  assign at_end    = (count <= CNT_W'(1)) || (idx_q == count - CNT_W'(1));
  assign carry_out = step_in && at_end;

  always_comb begin
    idx_nx = idx_q;
    off_nx = off_q;
    if (clr || (step_in && at_end)) begin
      idx_nx = '0;
      off_nx = '0;
    end else if (step_in) begin
      idx_nx = idx_q + CNT_W'(1);
      off_nx = off_q + stride;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      off_q <= '0;
    end else begin
      idx_q <= idx_nx;
      off_q <= off_nx;
    end
  end

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (count <= CNT_W'(1)) ? (idx_q == '0) : (idx_q < count));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int LOCAL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_store,
  input  logic               start_buf,
  input  logic               ready,
  input  logic               final_beat,
  output logic               clr,
  output logic               adv,
  output logic               busy,
  output logic [LOCAL_W-1:0] local_idx,
  output logic               store_q,
  output logic               buf_q,
  output logic               cur_tag,
  output logic               done,
  output logic [1:0]         tags
);
  assign clr = start && !busy;
  assign adv = busy && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      tags      <= 2'b00;
      local_idx <= '0;
      store_q   <= 1'b0;
      buf_q     <= 1'b0;
      cur_tag   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        busy      <= 1'b1;
        store_q   <= start_store;
        buf_q     <= start_buf;
        cur_tag   <= tags[start_buf];
        local_idx <= '0;
      end else if (adv) begin
        if (final_beat) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          tags[buf_q] <= ~tags[buf_q];
        end else begin
          local_idx <= local_idx + LOCAL_W'(1);
        end
      end
    end
  end

  // R5
  hold_local_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !ready |=> busy && $stable(local_idx));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy) && $past(ready));
  // R8
  tag_flip_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones(tags ^ $past(tags)) == 1);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(store_q) && $stable(buf_q) && $stable(cur_tag));
endmodule

// File: rtl/tile_xfer_agen.sv
module tile_xfer_agen #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int LOCAL_W = 16,
  parameter int LEVELS  = 4,
  localparam int NL     = 2 * LEVELS,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_func,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic [ADDR_W-1:0]  cfg_data,
  input  logic               start,
  input  logic               start_store,
  input  logic               start_buf,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LOCAL_W-1:0] req_local,
  output logic               req_store,
  output logic               req_buf,
  output logic               req_tag,
  output logic               done,
  output logic [1:0]         buf_tag
);
  logic [ADDR_W-1:0]          base;
  logic [NL-1:0][CNT_W-1:0]   cnt;
  logic [NL-1:0][ADDR_W-1:0]  stride;
  logic [NL-1:0][ADDR_W-1:0]  off_nx;
  logic [NL:0]                carry;
  logic                       clr, adv, busy;
  logic [ADDR_W-1:0]          addr_sum, addr_q;

  xfer_cfg_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .busy(busy), .we(cfg_we), .func(cfg_func),
    .lvl(cfg_level), .data(cfg_data), .base(base), .cnt(cnt), .stride(stride)
  );

  assign carry[0] = adv;

  for (genvar l = 0; l < NL; l++) begin : g_level
    xfer_loop_level #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_lvl (
      .clk(clk), .rst(rst), .clr(clr), .step_in(carry[l]),
      .count(cnt[l]), .stride(stride[l]),
      .carry_out(carry[l+1]), .off_nx(off_nx[l])
    );
  end

  xfer_seq #(.LOCAL_W(LOCAL_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_store(start_store),
    .start_buf(start_buf), .ready(req_ready), .final_beat(carry[NL]),
    .clr(clr), .adv(adv), .busy(busy), .local_idx(req_local),
    .store_q(req_store), .buf_q(req_buf), .cur_tag(req_tag),
    .done(done), .tags(buf_tag)
  );

  always_comb begin
    addr_sum = base;
    for (int l = 0; l < NL; l++) addr_sum = addr_sum + off_nx[l];
  end

  always_ff @(posedge clk) begin
    if (rst)              addr_q <= '0;
    else if (clr || adv)  addr_q <= addr_sum;
  end

  assign req_addr  = addr_q;
  assign req_valid = busy;

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R11
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    start && !req_valid |=> req_valid && (req_local == '0));
  // R7
  done_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);
endmodule

// File: tb/test_tile_xfer_agen.sv
`timescale 1ns/1ps
module test_tile_xfer_agen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_func = '0;
  logic [1:0]  cfg_level = '0;
  logic [31:0] cfg_data = '0;
  logic        start = 1'b0, start_store = 1'b0, start_buf = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [15:0] req_local;
  logic        req_store, req_buf, req_tag, done;
  logic [1:0]  buf_tag;

  int tests = 0, fails = 0, done_cnt = 0, cyc = 0, rcnt = 0, rmode = 0;
  logic [31:0] q_addr[$];
  logic [15:0] q_local[$];
  logic [2:0]  q_meta[$];
  logic [31:0] m_base;
  logic [31:0] m_cnt[8];
  logic [31:0] m_str[8];
  logic [1:0]  m_tag;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  tile_xfer_agen i_tile_xfer_agen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_func(cfg_func),
    .cfg_level(cfg_level), .cfg_data(cfg_data), .start(start),
    .start_store(start_store), .start_buf(start_buf), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_local(req_local),
    .req_store(req_store), .req_buf(req_buf), .req_tag(req_tag),
    .done(done), .buf_tag(buf_tag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern, driven away from the active edge
  always @(negedge clk) begin
    rcnt++;
    case (rmode)
      0:       req_ready <= 1'b1;
      1:       req_ready <= (rcnt % 3) != 0;
      default: req_ready <= rcnt[2];
    endcase
  end

  // monitor: pops the scoreboard on every accepted beat
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_stall && req_valid)
        check(req_addr == prev_addr, "R5 addr held under stall", req_addr, prev_addr);
      if (req_valid && req_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R3 unexpected beat", req_addr, 32'hffff_ffff);
        end else begin
          logic [31:0] ea; logic [15:0] el; logic [2:0] em;
          ea = q_addr.pop_front(); el = q_local.pop_front(); em = q_meta.pop_front();
          check(req_addr == ea, "R3 address", req_addr, ea);
          check(req_local == el, "R6 local index", 32'(req_local), 32'(el));
          check({req_tag, req_buf, req_store} == em, "R6 tag/buf/dir",
                32'({req_tag, req_buf, req_store}), 32'(em));
        end
      end
      prev_stall = req_valid && !req_ready;
      prev_addr  = req_addr;
      if (done) begin
        done_cnt++;
        check(!req_valid, "R7 valid low with done", 32'(req_valid), 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cfg(input int fn, input int lvl, input logic [31:0] d, input bit taken);
    @(negedge clk);
    cfg_we = 1'b1; cfg_func = 3'(fn); cfg_level = 2'(lvl); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (taken) begin
      case (fn)
        0: m_base = d;
        1: m_cnt[4+lvl] = {16'd0, d[15:0]};
        2: m_str[4+lvl] = d;
        3: m_cnt[lvl] = {16'd0, d[15:0]};
        4: m_str[lvl] = d;
        default: ;
      endcase
    end
  endtask

  // driver: pushes the expected beats, then pulses start
  task automatic go(input bit st, input bit bsel, input bit taken);
    if (taken) begin
      int total = 1;
      for (int l = 0; l < 8; l++) total *= (m_cnt[l] <= 1) ? 1 : int'(m_cnt[l]);
      for (int b = 0; b < total; b++) begin
        int r = b;
        logic [31:0] a = m_base;
        for (int l = 0; l < 8; l++) begin
          int c = (m_cnt[l] <= 1) ? 1 : int'(m_cnt[l]);
          a += 32'(r % c) * m_str[l];
          r /= c;
        end
        q_addr.push_back(a); q_local.push_back(16'(b));
        q_meta.push_back({m_tag[bsel], bsel, st});
      end
      m_tag[bsel] = ~m_tag[bsel];
    end
    @(negedge clk);
    start = 1'b1; start_store = st; start_buf = bsel;
    @(negedge clk);
    start = 1'b0;
    if (taken) begin
      #1;
      check(req_valid, "R11 valid after start", 32'(req_valid), 1);
    end
  endtask

  task automatic finish_xfer(input string tag);
    int d0 = done_cnt;
    int n = 0;
    while (done_cnt == d0 && n < 20000) begin @(negedge clk); #2; n++; end
    check(done_cnt == d0 + 1, {tag, " R7 one done pulse"}, 32'(done_cnt - d0), 1);
    @(negedge clk); #2;
    check(done_cnt == d0 + 1, {tag, " R7 single-cycle done"}, 32'(done_cnt - d0), 1);
    check(q_addr.size() == 0, {tag, " R3 all beats issued"}, 32'(q_addr.size()), 0);
    check(buf_tag == m_tag, {tag, " R8 buffer tags"}, 32'(buf_tag), 32'(m_tag));
  endtask

  initial begin
    m_base = '0; m_tag = '0;
    for (int l = 0; l < 8; l++) begin m_cnt[l] = 1; m_str[l] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check(!req_valid && !done && buf_tag == 2'b00, "R1 reset state",
          {29'd0, req_valid, buf_tag}, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check(!req_valid && !done && buf_tag == 2'b00, "R1 after reset",
          {29'd0, req_valid, buf_tag}, 0);

    // R2: defaults give a single beat at address 0
    go(1'b0, 1'b0, 1'b1);
    finish_xfer("defaults");

    // contiguous run into buffer 0, full-rate ready
    cfg(0, 0, 32'h1000, 1'b1);
    cfg(3, 0, 8, 1'b1);
    cfg(4, 0, 4, 1'b1);
    go(1'b0, 1'b0, 1'b1);
    finish_xfer("contiguous");

    // R3: 2-D tile stepped across two tiles, drain buffer 1, stalls
    rmode = 1;
    cfg(3, 1, 3, 1'b1);
    cfg(4, 0, 1, 1'b1);
    cfg(3, 0, 4, 1'b1);
    cfg(4, 1, 100, 1'b1);
    cfg(1, 0, 2, 1'b1);
    cfg(2, 0, 1000, 1'b1);
    go(1'b1, 1'b1, 1'b1);
    finish_xfer("strided 2d");

    // R4: all eight levels active except one with count 0
    rmode = 2;
    for (int l = 0; l < 4; l++) begin
      cfg(3, l, 2, 1'b1);
      cfg(4, l, 32'(1 << (2 * l)), 1'b1);
      cfg(1, l, (l == 2) ? 0 : 2, 1'b1);
      cfg(2, l, 32'(5000 * (l + 1)), 1'b1);
    end
    cfg(0, 0, 32'hFFFF_FF00, 1'b1);
    go(1'b0, 1'b1, 1'b1);
    finish_xfer("eight levels");

    // R9 and R10: start and configuration during a transfer are ignored
    rmode = 1;
    go(1'b1, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    go(1'b0, 1'b1, 1'b0);
    cfg(0, 0, 32'h0009_9990, 1'b0);
    cfg(3, 0, 7, 1'b0);
    finish_xfer("R9 start ignored");
    rmode = 0;
    go(1'b0, 1'b0, 1'b1);
    finish_xfer("R10 config kept");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule